// File: doc/BRIEF.md
# Array-Access Microcode Sequencer

This block sits between the bytecode translator and the execution unit of a stack pipeline. When the translator presents a request for one of the two array-access instructions, the sequencer takes it and closes its bytecode input. It then plays out a fixed list of internal opcodes to the execution unit, one opcode for each accepted valid/ready handshake. Each opcode carries a 16-bit operand.

Both lists first compute the byte address of the array element from the reference and the index on the stack. They do this by pushing 2, shifting left, pushing 4 and adding twice. They then issue the external word access. The store list first parks the value to be stored in global register 0. It parks the computed address in global register 1, then reads both back so the store-word opcode finds them on the stack in the right order. The final opcode of each list is flagged, and after that handshake the bytecode input opens again.

Top module: `mcseq_top`

## Requirements
- R1: After reset, `bc_ready` is 1, `exe_valid` is 0, `exe_last` is 0 and `req_err` is 0.
- R2: A request is taken in a cycle with `req_valid`=1 and `bc_ready`=1. If `req_entry`=1 or 2, then in the next cycle `exe_valid` is 1 and `bc_ready` is 0. `bc_ready` stays 0 until the cycle after the final opcode is accepted.
- R3: Entry 1 (array load) issues these opcodes in order: 0x40, 0xC1, 0x40, 0x30, 0x30, 0x12.
- R4: Entry 2 (array store) issues these opcodes in order: 0xFA, 0x40, 0xC1, 0x40, 0x30, 0x30, 0xFB, 0xF2, 0xF3, 0x22.
- R5: The first push (0x40) of each list carries operand 2 and the second carries operand 4. Every other opcode carries operand 0.
- R6: While `exe_valid`=1 and `exe_ready`=0, the opcode, operand and last flag hold their values and `exe_valid` stays 1. A step advances only on a cycle with `exe_ready`=1.
- R7: `exe_last` is 1 only with the final opcode of a list (0x12 or 0x22). In the cycle after that opcode is accepted, `exe_valid` is 0 and `bc_ready` is 1.
- R8: A request taken with any `req_entry` other than 1 or 2 starts no sequence. `exe_valid` stays 0 and `bc_ready` stays 1, and `req_err` is 1 for exactly the next cycle.
- R9: `req_valid` is ignored while `bc_ready` is 0. It neither changes the running list nor raises `req_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translator presents a microcoded request |
| req_entry | input | 8 | Microcode entry address of the request |
| bc_ready | output | 1 | Bytecode input may be accepted |
| exe_valid | output | 1 | An opcode is offered to the execution unit |
| exe_opcode | output | 8 | Internal opcode of the current step |
| exe_operand | output | 16 | Operand of the current step |
| exe_last | output | 1 | Current step is the final one of its list |
| exe_ready | input | 1 | Execution unit accepts the offered opcode |
| req_err | output | 1 | One-cycle pulse for a request to an unknown entry |

## Verification
Every output is registered or decoded from registered state. A request taken at a clock edge therefore shows up on `exe_valid`, `bc_ready` or `req_err` one edge later. Each step accepted at an edge presents the next opcode one edge later, and the final acceptance reopens `bc_ready` one edge later. The bench keeps a behavioural model that advances on the same edge from the same sampled inputs. It compares every output at the falling edge, half a period after the edge that could have changed them. Stall patterns on `exe_ready` and requests held during a running list test R6 and R9 against the same model.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;

    localparam int OP_W   = 8;
    localparam int OPND_W = 16;
    localparam int STEP_W = 4;

    localparam logic [OP_W-1:0] OPC_PUSH = 8'h40;
    localparam logic [OP_W-1:0] OPC_SHL  = 8'hC1;
    localparam logic [OP_W-1:0] OPC_ADD  = 8'h30;
    localparam logic [OP_W-1:0] OPC_LDW  = 8'h12;
    localparam logic [OP_W-1:0] OPC_STW  = 8'h22;
    localparam logic [OP_W-1:0] OPC_WG0  = 8'hFA;
    localparam logic [OP_W-1:0] OPC_WG1  = 8'hFB;
    localparam logic [OP_W-1:0] OPC_RG0  = 8'hF2;
    localparam logic [OP_W-1:0] OPC_RG1  = 8'hF3;

    // length of the shared address-calculation run
    localparam int CALC_LEN = 5;

    typedef enum logic {
        SEQ_LOAD  = 1'b0,
        SEQ_STORE = 1'b1
    } seq_t;

    typedef struct packed {
        logic [OP_W-1:0]   opc;
        logic [OPND_W-1:0] opnd;
        logic              last;
    } uop_t;

    typedef struct packed {
        logic              busy;
        seq_t              sel;
        logic [STEP_W-1:0] step;
        logic              err;
    } ctl_t;

endpackage

// File: rtl/mcseq_decode.sv
module mcseq_decode
    import mcseq_pkg::*;
#(
    parameter int ENTRY_W     = 8,
    parameter int LOAD_ENTRY  = 1,
    parameter int STORE_ENTRY = 2
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               known,
    output seq_t               sel
);
    localparam logic [ENTRY_W-1:0] LD_CODE = ENTRY_W'(LOAD_ENTRY);
    localparam logic [ENTRY_W-1:0] ST_CODE = ENTRY_W'(STORE_ENTRY);

    always_comb begin
        known = 1'b0;
        sel   = SEQ_LOAD;
        if (entry == LD_CODE) begin
            known = 1'b1;
            sel   = SEQ_LOAD;
        end else if (entry == ST_CODE) begin
            known = 1'b1;
            sel   = SEQ_STORE;
        end
    end
endmodule

// File: rtl/mcseq_rom.sv
module mcseq_rom
    import mcseq_pkg::*;
(
    input  seq_t              sel,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);
    localparam int LOAD_LEN  = CALC_LEN + 1;
    localparam int STORE_LEN = CALC_LEN + 5;

    // address calculation: push 2, shl, push 4, add, add
    function automatic uop_t calc_step(input int k);
        uop_t u;
        u = '0;
        case (k)
            0: begin u.opc = OPC_PUSH; u.opnd = OPND_W'(2); end
            1: u.opc = OPC_SHL;
            2: begin u.opc = OPC_PUSH; u.opnd = OPND_W'(4); end
            default: u.opc = OPC_ADD;
        endcase
        return u;
    endfunction

    uop_t ld_uop;
    uop_t st_uop;

    always_comb begin
        ld_uop = '0;
        if (int'(step) < CALC_LEN) begin
            ld_uop = calc_step(int'(step));
        end else begin
            ld_uop.opc  = OPC_LDW;
            ld_uop.last = 1'b1;
        end
    end

    always_comb begin
        st_uop = '0;
        if (step == '0) begin
            st_uop.opc = OPC_WG0;
        end else if (int'(step) <= CALC_LEN) begin
            st_uop = calc_step(int'(step) - 1);
        end else if (int'(step) == CALC_LEN + 1) begin
            st_uop.opc = OPC_WG1;
        end else if (int'(step) == CALC_LEN + 2) begin
            st_uop.opc = OPC_RG0;
        end else if (int'(step) == CALC_LEN + 3) begin
            st_uop.opc = OPC_RG1;
        end else begin
            st_uop.opc  = OPC_STW;
            st_uop.last = 1'b1;
        end
    end

    assign uop = (sel == SEQ_STORE) ? st_uop : ld_uop;

    always_comb begin
        if (uop.last) begin
            assert_last_final_R7: assert (uop.opc == OPC_LDW || uop.opc == OPC_STW);
        end
    end

    initial begin
        assert_len_fit_R4: assert (STORE_LEN <= (1 << STEP_W) && LOAD_LEN < STORE_LEN);
    end
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
    import mcseq_pkg::*;
#(
    parameter int ENTRY_W     = 8,
    parameter int LOAD_ENTRY  = 1,
    parameter int STORE_ENTRY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ENTRY_W-1:0] req_entry,
    output logic               bc_ready,
    output logic               exe_valid,
    output logic [OP_W-1:0]    exe_opcode,
    output logic [OPND_W-1:0]  exe_operand,
    output logic               exe_last,
    input  logic               exe_ready,
    output logic               req_err
);
    ctl_t ctl_d, ctl_q;
    logic entry_known;
    seq_t entry_sel;
    uop_t cur_uop;

    mcseq_decode #(
        .ENTRY_W    (ENTRY_W),
        .LOAD_ENTRY (LOAD_ENTRY),
        .STORE_ENTRY(STORE_ENTRY)
    ) i_decode (
        .entry(req_entry),
        .known(entry_known),
        .sel  (entry_sel)
    );

    mcseq_rom i_rom (
        .sel (ctl_q.sel),
        .step(ctl_q.step),
        .uop (cur_uop)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        if (!ctl_q.busy) begin
            if (req_valid) begin
                if (entry_known) begin
                    ctl_d.busy = 1'b1;
                    ctl_d.sel  = entry_sel;
                    ctl_d.step = '0;
                end else begin
                    ctl_d.err = 1'b1;
                end
            end
        end else if (exe_ready) begin
            if (cur_uop.last) begin
                ctl_d.busy = 1'b0;
                ctl_d.step = '0;
            end else begin
                ctl_d.step = ctl_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bc_ready    = !ctl_q.busy;
    assign exe_valid   = ctl_q.busy;
    assign exe_opcode  = ctl_q.busy ? cur_uop.opc  : '0;
    assign exe_operand = ctl_q.busy ? cur_uop.opnd : '0;
    assign exe_last    = ctl_q.busy & cur_uop.last;
    assign req_err     = ctl_q.err;

    assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid && !exe_ready |=> exe_valid && $stable(exe_opcode)
                                    && $stable(exe_operand) && $stable(exe_last));

    assert_operand_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid && exe_opcode != OPC_PUSH |-> exe_operand == '0);

    assert_input_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> !bc_ready);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid && exe_ready && exe_last |=> bc_ready && !exe_valid);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && bc_ready && !entry_known |=> req_err && !exe_valid);

    assert_busy_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_ready |=> !req_err);
endmodule

// File: tb/test_mcseq_top.sv
module test_mcseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_entry = '0;
    logic        exe_ready = 1'b0;
    logic        bc_ready, exe_valid, exe_last, req_err;
    logic [7:0]  exe_opcode;
    logic [15:0] exe_operand;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcseq_top i_mcseq_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_entry(req_entry),
        .bc_ready(bc_ready), .exe_valid(exe_valid), .exe_opcode(exe_opcode),
        .exe_operand(exe_operand), .exe_last(exe_last), .exe_ready(exe_ready),
        .req_err(req_err)
    );

    // reference model: queue of {last, opcode, operand}
    logic [24:0] m_q[$];
    bit m_busy = 0;
    bit m_err = 0;
    bit m_store = 0;
    bit m_stalled = 0;

    function automatic logic [24:0] w(bit l, logic [7:0] o, logic [15:0] d);
        return {l, o, d};
    endfunction

    always @(posedge clk) begin
        m_err = 0;
        m_stalled = 0;
        if (!rst_n) begin
            m_busy = 0;
            m_q.delete();
        end else if (!m_busy) begin
            if (req_valid) begin
                if (req_entry == 8'd1) begin
                    m_store = 0; m_busy = 1;
                    m_q = '{w(0,8'h40,2), w(0,8'hC1,0), w(0,8'h40,4), w(0,8'h30,0),
                           w(0,8'h30,0), w(1,8'h12,0)};
                end else if (req_entry == 8'd2) begin
                    m_store = 1; m_busy = 1;
                    m_q = '{w(0,8'hFA,0), w(0,8'h40,2), w(0,8'hC1,0), w(0,8'h40,4),
                           w(0,8'h30,0), w(0,8'h30,0), w(0,8'hFB,0), w(0,8'hF2,0),
                           w(0,8'hF3,0), w(1,8'h22,0)};
                end else begin
                    m_err = 1;
                end
            end
        end else if (exe_ready) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0) m_busy = 0;
        end else begin
            m_stalled = 1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2 bc_ready", 32'(bc_ready), 32'(!m_busy));
            chk("R2 exe_valid", 32'(exe_valid), 32'(m_busy));
            chk("R8 req_err", 32'(req_err), 32'(m_err));
            if (m_busy) begin
                chk(m_stalled ? "R6 opcode held" : (m_store ? "R4 opcode" : "R3 opcode"),
                    32'(exe_opcode), 32'(m_q[0][23:16]));
                chk("R5 operand", 32'(exe_operand), 32'(m_q[0][15:0]));
                chk("R7 last", 32'(exe_last), 32'(m_q[0][24]));
            end else begin
                chk("R7 last idle", 32'(exe_last), 32'd0);
            end
        end
    end

    task automatic run_seq(logic [7:0] e, int stall_mod, bit hold_req);
        req_valid = 1; req_entry = e;
        @(negedge clk);
        req_valid = hold_req; req_entry = 8'd3;  // R9: invalid entry offered while busy
        for (int i = 0; i < 40 && exe_valid; i++) begin
            exe_ready = (stall_mod == 0) ? 1'b1 : ((i % stall_mod) != 0);
            @(negedge clk);
        end
        req_valid = 0; exe_ready = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset bc_ready", 32'(bc_ready), 32'd1);
        chk("R1 reset exe_valid", 32'(exe_valid), 32'd0);
        chk("R1 reset last", 32'(exe_last), 32'd0);
        chk("R1 reset err", 32'(req_err), 32'd0);
        rst_n = 1;
        @(negedge clk);
        run_seq(8'd1, 0, 0);
        run_seq(8'd2, 0, 0);
        run_seq(8'd1, 3, 1);
        run_seq(8'd2, 2, 1);
        exe_ready = 1;
        run_seq(8'd2, 4, 0);
        foreach (req_entry[i]) begin end
        req_valid = 1; req_entry = 8'd0;  @(negedge clk);
        req_valid = 0;                    @(negedge clk);
        req_valid = 1; req_entry = 8'hFF; @(negedge clk);
        req_entry = 8'd3;                 @(negedge clk);
        req_valid = 0;                    @(negedge clk);
        // back-to-back: new request taken the cycle bc_ready reopens
        req_valid = 1; req_entry = 8'd1; exe_ready = 1;
        repeat (16) @(negedge clk);
        req_valid = 0;
        repeat (12) @(negedge clk);
        done = 1;
    end

    initial begin
        while (!done && cycles < 5000) @(negedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule